// File: doc/BRIEF.md
# Fixed-Period PWM Output Stage

This block produces a pulse-width-modulated signal with a constant 1 ms period. A prescaler divides the system clock into 256 equal steps per period, and an 8-bit step counter runs freely through them. The output is high while the step count does not exceed an 8-bit duty level. Both the duty level and an output-enable flag sit in a small byte-wide register space written over a simple address/data/strobe port. The serial link that feeds this port, the pad and clock generation all live outside the block.

Because the high time is one step longer than the stored level, the shortest pulse is 1/256 of the period and the longest is the whole period. No duty level gives a constant low. Turning the output off does not pull the pin low. It drops the pad's output-enable so that the pin floats. Register writes reach the output straight away. There is no shadow copy and nothing waits for the next period, so a mid-period write can cut a pulse short or stretch it. The period itself never restarts. The polarity is fixed active-high.

Top module: `fixed_pwm_gen`

## Requirements
- R1: A synchronous active-high reset clears the step counter, the duty register (0xD8) and the control register (0xD2). After reset both read back as 0 and `pwm_oe` is 0.
- R2: The counter takes one step every `SYS_CLK_HZ/(PERIOD_HZ*256)` clock cycles and wraps from 255 to 0. Rising edges of `pwm_out` at the wrap are therefore exactly 256 steps apart, and writes to either register never shift them.
- R3: With output enabled and duty value D, `pwm_out` is high for (D+1) steps out of every 256. D=0 gives one step, and D=255 keeps the output high for the whole period.
- R4: `pwm_oe` equals bit 7 of register 0xD2. `pwm_out` is high only when that bit is 1 and the step count is less than or equal to the duty value. While bit 7 is 0, `pwm_oe` and `pwm_out` both stay 0.
- R5: A write to 0xD8 or to 0xD2 is visible on the outputs in the first cycle after the strobe edge, whatever the step count. Raising the duty above the current count drives the output high at once, and lowering it below the count drives the output low at once.
- R6: Register 0xD2 stores all 8 written bits and reads them back. Only bit 7 has any effect on the outputs, so changing bits 6..0 leaves the output behaviour unchanged.
- R7: The duty register keeps its value while the output is disabled. A level written before enabling is the one used once bit 7 is set.
- R8: `reg_rdata` shows the contents of the addressed register combinationally. Any address other than 0xD2 or 0xD8 reads as 0, and writes to such addresses change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| pwm_out | output | 1 | PWM data value to the pad |
| pwm_oe | output | 1 | Pad output-enable; 0 floats the pin |

## Verification
High time is measured over a full period for the duty levels 0, 37, 128 and 255. These show the one-step offset and the two end points, which a plain `count < duty` comparator would get wrong. Duty writes are also made just after a falling edge and just after a rising edge. These two cases separate a design that applies the new level at once from one that holds it until the next period. A write that changes nothing visible is placed between two rising edges, and the spacing of those edges is checked to confirm the period keeps running. A disabled full period, a preload before enable, a write to bits 6..0 of 0xD2 and an unmapped write complete the set.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int unsigned STEP_W      = 8;
    localparam int unsigned STEPS       = 1 << STEP_W;
    localparam int unsigned REG_W       = 8;

    localparam logic [7:0]  ADDR_CTRL   = 8'hD2;
    localparam logic [7:0]  ADDR_LEVEL  = 8'hD8;
    localparam int unsigned CTRL_EN_BIT = 7;

    typedef logic [STEP_W-1:0] step_t;

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] level;
    } pwm_regs_t;

    function automatic logic drive_level(input step_t count,
                                         input step_t level,
                                         input logic  en);
        return en && (count <= level);
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int unsigned DIV = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic step_tick
);
    localparam int unsigned DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV <= 1) begin : g_passthru
            assign step_tick = 1'b1;
        end else begin : g_divide
            logic [DIV_W-1:0] div_q;
            localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

            always_ff @(posedge clk) begin
                if (rst)
                    div_q <= '0;
                else if (div_q == LAST)
                    div_q <= '0;
                else
                    div_q <= div_q + 1'b1;
            end

            assign step_tick = (div_q == LAST);

            // R2: divider never leaves its range
            a_r2_div_range: assert property (@(posedge clk) disable iff (rst)
                div_q <= LAST);
            // R2: a tick is followed by a restart of the divider
            a_r2_div_restart: assert property (@(posedge clk) disable iff (rst)
                step_tick |=> (div_q == '0));
        end
    endgenerate

endmodule

// File: rtl/pwm_step_counter.sv
module pwm_step_counter
    import pwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step_tick,
    output step_t count
);
    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (step_tick)
            count <= count + 1'b1;
    end

    // R2: advances by exactly one step per tick, wrapping at the top
    a_r2_step_advance: assert property (@(posedge clk) disable iff (rst)
        step_tick |=> (count == step_t'($past(count) + 1'b1)));
    // R2: holds between ticks, so register writes cannot move it
    a_r2_step_hold: assert property (@(posedge clk) disable iff (rst)
        !step_tick |=> $stable(count));

endmodule

// File: rtl/pwm_ctrl_regs.sv
module pwm_ctrl_regs
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             reg_we,
    output logic [REG_W-1:0] reg_rdata,
    output pwm_regs_t        regs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                ADDR_CTRL:  regs.ctrl  <= reg_wdata;
                ADDR_LEVEL: regs.level <= reg_wdata;
                default:    ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_CTRL:  reg_rdata = regs.ctrl;
            ADDR_LEVEL: reg_rdata = regs.level;
            default:    reg_rdata = '0;
        endcase
    end

    // R1: both registers are clear in the first cycle after reset
    a_r1_regs_cleared: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (regs == '0));
    // R5: a duty write lands on the very next edge
    a_r5_level_write: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == ADDR_LEVEL) |=> (regs.level == $past(reg_wdata)));
    // R7: the duty level only changes through its own address
    a_r7_level_kept: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr == ADDR_LEVEL) |=> $stable(regs.level));
    // R8: unmapped writes leave every register as it was
    a_r8_unmapped_ignored: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr != ADDR_LEVEL && reg_addr != ADDR_CTRL) |=> $stable(regs));

endmodule

// File: rtl/fixed_pwm_gen.sv
module fixed_pwm_gen
    import pwm_pkg::*;
#(
    parameter int unsigned SYS_CLK_HZ = 256_000_000,
    parameter int unsigned PERIOD_HZ  = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic       reg_we,
    output logic [7:0] reg_rdata,
    output logic       pwm_out,
    output logic       pwm_oe
);
    localparam int unsigned CLK_PER_STEP = SYS_CLK_HZ / (PERIOD_HZ * STEPS);

    logic      step_tick;
    step_t     count;
    pwm_regs_t regs;
    logic      en;

    pwm_prescaler #(.DIV(CLK_PER_STEP)) u_presc (
        .clk       (clk),
        .rst       (rst),
        .step_tick (step_tick)
    );

    pwm_step_counter u_count (
        .clk       (clk),
        .rst       (rst),
        .step_tick (step_tick),
        .count     (count)
    );

    pwm_ctrl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .regs      (regs)
    );

    assign en      = regs.ctrl[CTRL_EN_BIT];
    assign pwm_oe  = en;
    assign pwm_out = drive_level(count, regs.level, en);

    // R4: a floating pin never carries a high data value
    a_r4_float_low: assert property (@(posedge clk) disable iff (rst)
        !pwm_oe |-> !pwm_out);
    // R3: every enabled period starts high, since the shortest pulse is one step
    a_r3_first_step_high: assert property (@(posedge clk) disable iff (rst)
        (pwm_oe && count == '0) |-> pwm_out);
    // R3: top duty level holds the output high throughout
    a_r3_full_scale: assert property (@(posedge clk) disable iff (rst)
        (pwm_oe && regs.level == 8'hFF) |-> pwm_out);
    // R5: enable write reaches the pad enable on the next edge
    a_r5_enable_write: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == ADDR_CTRL) |=> (pwm_oe == $past(reg_wdata[CTRL_EN_BIT])));

endmodule

// File: tb/fixed_pwm_gen_test.sv
`timescale 1ns/1ps
module fixed_pwm_gen_test;

    localparam int unsigned DIV    = 3;
    localparam int unsigned PERIOD = 256 * DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic       reg_we = 1'b0;
    logic [7:0] reg_rdata;
    logic       pwm_out;
    logic       pwm_oe;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fixed_pwm_gen #(.SYS_CLK_HZ(256 * 1000 * DIV), .PERIOD_HZ(1000)) uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic count_high(output int highs, output int oes);
        highs = 0; oes = 0;
        for (int i = 0; i < PERIOD; i++) begin
            @(negedge clk);
            if (pwm_out) highs++;
            if (pwm_oe) oes++;
        end
    endtask

    task automatic wait_rise(output int at);
        logic prev;
        prev = pwm_out;
        for (int i = 0; i < 4 * PERIOD; i++) begin
            @(negedge clk);
            if (pwm_out && !prev) break;
            prev = pwm_out;
        end
        at = cyc;
    endtask

    task automatic wait_fall();
        logic prev;
        prev = pwm_out;
        for (int i = 0; i < 4 * PERIOD; i++) begin
            @(negedge clk);
            if (!pwm_out && prev) break;
            prev = pwm_out;
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(8'hD2, d); check(d == 0, "R1 ctrl after reset", d, 0);
        rd(8'hD8, d); check(d == 0, "R1 duty after reset", d, 0);
        check(pwm_oe == 0, "R1 oe after reset", pwm_oe, 0);
    endtask

    task automatic t_duty_sweep();
        int h, o;
        int levels[4] = '{0, 37, 128, 255};
        wr(8'hD2, 8'h80);
        foreach (levels[k]) begin
            wr(8'hD8, 8'(levels[k]));
            count_high(h, o);
            check(h == (levels[k] + 1) * DIV, "R3 high time", h, (levels[k] + 1) * DIV);
            check(o == PERIOD, "R4 oe held while enabled", o, PERIOD);
        end
    endtask

    task automatic t_immediate();
        int r1, r2;
        wr(8'hD8, 8'd20);
        wait_fall();
        wr(8'hD8, 8'd200);
        check(pwm_out == 1, "R5 raise mid-period", pwm_out, 1);
        wait_rise(r1);
        repeat (2 * DIV) @(negedge clk);
        wr(8'hD8, 8'd1);
        check(pwm_out == 0, "R5 drop mid-period", pwm_out, 0);
        wr(8'hD8, 8'd0);
        wait_rise(r1);
        repeat (400) @(negedge clk);
        wr(8'hD8, 8'd100);
        wr(8'hD8, 8'd5);
        wait_rise(r2);
        check(r2 - r1 == PERIOD, "R2 period kept across writes", r2 - r1, PERIOD);
    endtask

    task automatic t_disable_preload();
        int h, o;
        logic [7:0] d;
        wr(8'hD2, 8'h00);
        check(pwm_oe == 0, "R5 disable immediate", pwm_oe, 0);
        wr(8'hD8, 8'd63);
        count_high(h, o);
        check(o == 0, "R4 oe low while disabled", o, 0);
        check(h == 0, "R4 data low while disabled", h, 0);
        rd(8'hD8, d); check(d == 63, "R7 duty kept while disabled", d, 63);
        wr(8'hD2, 8'h80);
        count_high(h, o);
        check(h == 64 * DIV, "R7 preloaded duty used", h, 64 * DIV);
    endtask

    task automatic t_ctrl_bits();
        int h, o;
        logic [7:0] d;
        wr(8'hD2, 8'h85);
        rd(8'hD2, d); check(d == 8'h85, "R6 ctrl readback", d, 8'h85);
        count_high(h, o);
        check(h == 64 * DIV, "R6 low bits no effect", h, 64 * DIV);
        wr(8'hD2, 8'h05);
        rd(8'hD2, d); check(d == 8'h05, "R6 low bits kept", d, 8'h05);
        check(pwm_oe == 0, "R6 bit 7 alone gates", pwm_oe, 0);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        wr(8'h10, 8'hFF);
        wr(8'hD3, 8'hFF);
        rd(8'h10, d); check(d == 0, "R8 unmapped reads zero", d, 0);
        rd(8'hD2, d); check(d == 8'h05, "R8 ctrl untouched", d, 8'h05);
        rd(8'hD8, d); check(d == 63, "R8 duty untouched", d, 63);
        check(pwm_oe == 0, "R8 output untouched", pwm_oe, 0);
    endtask

    initial begin
        t_reset();
        t_duty_sweep();
        t_immediate();
        t_disable_preload();
        t_ctrl_bits();
        t_unmapped();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule